// File: doc/BRIEF.md
# Frequency Synthesiser Loop Logic Core

This block is the digital heart of a single-loop frequency synthesiser. A reference divider turns a reference timebase into a comparison strobe, and a 15-bit programmable divider turns the prescaled oscillator into a feedback strobe. A tri-state phase/frequency detector compares the two strobes and produces pump-up and pump-down requests. A lock monitor watches the widths of those requests and raises a lock flag. A control decoder turns the programmed control fields into these outputs: pump requests, a pump current level, a pump disable, a drive disable, the reported lock flag and forced test-point outputs.

The block runs on one system clock. The reference and the prescaled oscillator arrive as single-cycle enable strobes (`ref_tick`, `rf_tick`). Every output is registered, so it follows its inputs with one clock of delay. The control fields come from a register interface elsewhere on the chip and are treated here as static levels. The reference ratio is selected by `tsel[0]`. The test behaviour is chosen by `tsel[2:1]` when `test_en` is high.

Top module: `synth_loop_core`

## Requirements
- R1: The feedback divider emits one strobe every N `rf_tick` strobes, where N is `ratio`. A ratio of 0 or 1 gives a strobe on every `rf_tick`. A new ratio is loaded only at terminal count, so the period already running ends unchanged.
- R2: The comparison strobe comes once every 512 `ref_tick` strobes when `tsel[0]`=1 and once every 1024 when `tsel[0]`=0. A change of `tsel[0]` takes effect at the next terminal count.
- R3: `pump_up` is high from a comparison strobe until the next feedback strobe, and `pump_dn` is high from a feedback strobe until the next comparison strobe. Strobes in the same cycle produce no request, and the two requests are never high together.
- R4: The loop counts as locked after 4 consecutive comparison strobes in which no request lasted 4 `ref_tick` strobes. It drops out of lock as soon as a request reaches 4 `ref_tick` strobes.
- R5: `cur_high` equals `cur_sel` while the loop is unlocked and is 0 while it is locked.
- R6: With `pump_kill`=1, `pump_up` and `pump_dn` are both 0, even in a forced test mode, and `pump_off` is 1.
- R7: `drive_off` follows `drive_kill`.
- R8: With `test_en`=0, `tsel[2:1]` has no effect: both test points stay disabled and the pump and lock flag follow the loop.
- R9: With `test_en`=1 and `tsel[2:1]`=00, the pump is held down (`pump_dn`=1, `pump_up`=0) and `lock_flag`=0. With `tsel[2:1]`=01, the pump is held up and `lock_flag`=1.
- R10: With `test_en`=1 and `tsel`=101, `tp_a_en`=1 and `tp_a_val` toggles on every feedback strobe, giving a square wave at half the feedback rate. `tp_b_en`=0.
- R11: With `test_en`=1 and `tsel[2:1]`=11, `tp_a_en`=`tp_b_en`=1. `tp_a_val` carries the feedback strobe and `tp_b_val` carries the comparison strobe.
- R12: All outputs are registered and read 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | Reference timebase strobe |
| rf_tick | input | 1 | Prescaled oscillator strobe |
| ratio | input | 15 | Feedback division ratio |
| cur_sel | input | 1 | Request high pump current |
| pump_kill | input | 1 | Disable charge pump |
| drive_kill | input | 1 | Disable varactor drive |
| test_en | input | 1 | Enable test modes |
| tsel | input | 3 | Test/ratio select; bit 0 picks reference ratio |
| pump_up | output | 1 | Pump sink (up) request |
| pump_dn | output | 1 | Pump source (down) request |
| cur_high | output | 1 | High pump current select |
| pump_off | output | 1 | Pump disabled |
| drive_off | output | 1 | Drive amplifier disabled |
| lock_flag | output | 1 | Reported lock status |
| tp_a_en | output | 1 | Test point A override enable |
| tp_a_val | output | 1 | Test point A value |
| tp_b_en | output | 1 | Test point B override enable |
| tp_b_val | output | 1 | Test point B value |

## Verification
The divider is swept over small and large ratios. This is done once with a continuous oscillator strobe and once with a strobe on every third cycle, which shows apart a ratio error from a strobe-gating error. The degenerate ratios 0 and 1 are part of the sweep. The reference period is measured on the test point at both ratio settings. The detector is tried with three feedback ratios against a 512 reference. A matched ratio must lock with no requests. A short ratio must give only down requests of exactly 12 cycles, and a long ratio only up requests of exactly 12 cycles, each time with lock lost and current raised. The forced modes, the pump and drive disables and the ignored test selects are applied on a locked loop, so that forced values can be told apart from the values the loop produces.

// File: rtl/synth_loop_pkg.sv
package synth_loop_pkg;
    typedef struct packed {
        logic up;
        logic dn;
        logic cur_high;
        logic pump_off;
        logic drive_off;
        logic flag;
        logic a_en;
        logic a_val;
        logic b_en;
        logic b_val;
    } out_bits_t;

    typedef struct packed {
        out_bits_t out;
        logic      half;
    } top_state_t;
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] ratio,
    output logic         pulse
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         pulse;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (tick) begin
            if (st_q.cnt <= W'(1)) begin
                st_d.cnt   = ratio;
                st_d.pulse = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse = st_q.pulse;

    // R1 / R2: a ratio above one never yields strobes in adjacent cycles
    assert_no_back_to_back_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pulse && ratio > W'(1) && $stable(ratio)) |=> !st_q.pulse);
endmodule

// File: rtl/phase_detector.sv
module phase_detector (
    input  logic clk,
    input  logic rst_n,
    input  logic comp_p,
    input  logic fb_p,
    output logic up,
    output logic dn
);
    typedef struct packed {
        logic up;
        logic dn;
    } pfd_state_t;

    pfd_state_t st_d, st_q;

    always_comb begin
        st_d.up = st_q.up | comp_p;
        st_d.dn = st_q.dn | fb_p;
        if (st_d.up && st_d.dn) begin
            st_d.up = 1'b0;
            st_d.dn = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign up = st_q.up;
    assign dn = st_q.dn;

    assert_up_starts_on_comp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.up) |-> $past(comp_p));
    assert_dn_starts_on_fb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.dn) |-> $past(fb_p));
endmodule

// File: rtl/lock_monitor.sv
module lock_monitor #(
    parameter int LOCK_WIDTH = 4,
    parameter int LOCK_COUNT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic active,
    input  logic comp_p,
    output logic locked
);
    localparam int WW = $clog2(LOCK_WIDTH + 1);
    localparam int CW = $clog2(LOCK_COUNT + 1);

    typedef struct packed {
        logic [WW-1:0] width;
        logic [CW-1:0] good;
        logic          bad;
        logic          locked;
    } lock_state_t;

    lock_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!active)
            st_d.width = '0;
        else if (tick && st_q.width < WW'(LOCK_WIDTH))
            st_d.width = st_q.width + WW'(1);

        if (comp_p) begin
            if (st_q.bad) begin
                st_d.bad  = 1'b0;
                st_d.good = '0;
            end else if (st_q.good < CW'(LOCK_COUNT)) begin
                st_d.good = st_q.good + CW'(1);
                if (st_q.good + CW'(1) >= CW'(LOCK_COUNT))
                    st_d.locked = 1'b1;
            end
        end

        if (st_q.width == WW'(LOCK_WIDTH)) begin
            st_d.bad    = 1'b1;
            st_d.good   = '0;
            st_d.locked = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked = st_q.locked;

    assert_wide_pulse_unlocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.width == WW'(LOCK_WIDTH)) |=> !st_q.locked);
    assert_lock_on_comp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.locked) |-> $past(comp_p));
endmodule

// File: rtl/synth_loop_core.sv
module synth_loop_core #(
    parameter int RATIO_W    = 15,
    parameter int REF_SHORT  = 512,
    parameter int REF_LONG   = 1024,
    parameter int LOCK_WIDTH = 4,
    parameter int LOCK_COUNT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_tick,
    input  logic               rf_tick,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               cur_sel,
    input  logic               pump_kill,
    input  logic               drive_kill,
    input  logic               test_en,
    input  logic [2:0]         tsel,
    output logic               pump_up,
    output logic               pump_dn,
    output logic               cur_high,
    output logic               pump_off,
    output logic               drive_off,
    output logic               lock_flag,
    output logic               tp_a_en,
    output logic               tp_a_val,
    output logic               tp_b_en,
    output logic               tp_b_val
);
    import synth_loop_pkg::*;

    localparam int REF_W = $clog2(REF_LONG + 1);

    logic             comp_p, fb_p, pfd_up, pfd_dn, locked;
    logic [REF_W-1:0] ref_ratio;

    assign ref_ratio = tsel[0] ? REF_W'(REF_SHORT) : REF_W'(REF_LONG);

    tick_divider #(.W(REF_W)) u_ref_div (
        .clk(clk), .rst_n(rst_n), .tick(ref_tick), .ratio(ref_ratio), .pulse(comp_p)
    );

    tick_divider #(.W(RATIO_W)) u_fb_div (
        .clk(clk), .rst_n(rst_n), .tick(rf_tick), .ratio(ratio), .pulse(fb_p)
    );

    phase_detector u_pfd (
        .clk(clk), .rst_n(rst_n), .comp_p(comp_p), .fb_p(fb_p), .up(pfd_up), .dn(pfd_dn)
    );

    lock_monitor #(.LOCK_WIDTH(LOCK_WIDTH), .LOCK_COUNT(LOCK_COUNT)) u_lock (
        .clk(clk), .rst_n(rst_n), .tick(ref_tick), .active(pfd_up | pfd_dn),
        .comp_p(comp_p), .locked(locked)
    );

    top_state_t st_d, st_q;
    logic       forced;

    always_comb begin
        forced            = test_en & ~tsel[2];
        st_d.half         = st_q.half ^ fb_p;
        st_d.out.up       = forced ? tsel[1]  : pfd_up;
        st_d.out.dn       = forced ? ~tsel[1] : pfd_dn;
        if (pump_kill) begin
            st_d.out.up = 1'b0;
            st_d.out.dn = 1'b0;
        end
        st_d.out.pump_off  = pump_kill;
        st_d.out.drive_off = drive_kill;
        st_d.out.flag      = forced ? tsel[1] : locked;
        st_d.out.cur_high  = cur_sel & ~locked;
        st_d.out.a_en      = test_en & tsel[2] & (tsel[1] | tsel[0]);
        st_d.out.a_val     = st_d.out.a_en & (tsel[1] ? fb_p : st_q.half);
        st_d.out.b_en      = test_en & tsel[2] & tsel[1];
        st_d.out.b_val     = st_d.out.b_en & comp_p;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pump_up   = st_q.out.up;
    assign pump_dn   = st_q.out.dn;
    assign cur_high  = st_q.out.cur_high;
    assign pump_off  = st_q.out.pump_off;
    assign drive_off = st_q.out.drive_off;
    assign lock_flag = st_q.out.flag;
    assign tp_a_en   = st_q.out.a_en;
    assign tp_a_val  = st_q.out.a_val;
    assign tp_b_en   = st_q.out.b_en;
    assign tp_b_val  = st_q.out.b_val;

    assert_kill_idles_pump_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pump_kill |=> (!pump_up && !pump_dn && pump_off));
    assert_lock_forces_low_current_R5: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> !cur_high);
    assert_force_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && tsel[2:1] == 2'b01 && !pump_kill) |=> (pump_up && !pump_dn && lock_flag));
    assert_no_override_normal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> (!tp_a_en && !tp_b_en));
    assert_requests_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(pump_up && pump_dn));
endmodule

// File: tb/synth_loop_core_tb.sv
module synth_loop_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b1;
    logic        rf_tick = 1'b1;
    logic [14:0] ratio = 15'd512;
    logic        cur_sel = 1'b1, pump_kill = 1'b0, drive_kill = 1'b0, test_en = 1'b0;
    logic [2:0]  tsel = 3'b001;
    logic pump_up, pump_dn, cur_high, pump_off, drive_off, lock_flag;
    logic tp_a_en, tp_a_val, tp_b_en, tp_b_val;

    int checks = 0;
    int errors = 0;
    int rf_div = 1;
    int rf_cnt = 0;

    always #5 clk = ~clk;

    synth_loop_core u_dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .rf_tick(rf_tick), .ratio(ratio),
        .cur_sel(cur_sel), .pump_kill(pump_kill), .drive_kill(drive_kill),
        .test_en(test_en), .tsel(tsel), .pump_up(pump_up), .pump_dn(pump_dn),
        .cur_high(cur_high), .pump_off(pump_off), .drive_off(drive_off),
        .lock_flag(lock_flag), .tp_a_en(tp_a_en), .tp_a_val(tp_a_val),
        .tp_b_en(tp_b_en), .tp_b_val(tp_b_val)
    );

    // oscillator strobe: one in every rf_div cycles, restarted by reset
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) rf_cnt = 0;
            else rf_cnt = (rf_cnt + 1) % rf_div;
            rf_tick = (rf_cnt == 0);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // cycles between two rising edges of the chosen test point value
    task automatic period_of(input bit use_b, output int p);
        bit prev, cur;
        int n;
        p = -1;
        @(negedge clk);
        prev = use_b ? tp_b_val : tp_a_val;
        n = -1;
        for (int i = 0; i < 12000; i++) begin
            @(negedge clk);
            cur = use_b ? tp_b_val : tp_a_val;
            if (n >= 0) n++;
            if (cur && !prev) begin
                if (n >= 0) begin
                    p = n;
                    return;
                end
                n = 0;
            end
            prev = cur;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_neg(3);
        rst_n = 1'b1;
    endtask

    task automatic try_offset(input int r, input bit expect_up);
        int wrong, seen, width, first_w;
        bit in_pulse, done;
        test_en = 1'b0; tsel = 3'b001; ratio = 15'd512; rf_div = 1; cur_sel = 1'b1;
        do_reset();
        wait_neg(6 * 512);
        chk(lock_flag == 1'b1, "R4 lock on matched ratio", lock_flag, 1);
        chk(cur_high == 1'b0, "R5 low current while locked", cur_high, 0);
        ratio = 15'(r);
        wrong = 0; seen = 0; width = 0; first_w = -1; in_pulse = 0; done = 0;
        for (int i = 0; i < 4 * 512; i++) begin
            @(negedge clk);
            if ((expect_up ? pump_dn : pump_up)) wrong++;
            if ((expect_up ? pump_up : pump_dn)) begin
                seen++;
                in_pulse = 1;
                width++;
            end else if (in_pulse && !done) begin
                first_w = width;
                done = 1;
                in_pulse = 0;
            end
        end
        chk(seen > 0, "R3 expected request seen", seen, 1);
        chk(wrong == 0, "R3 opposite request absent", wrong, 0);
        chk(first_w == 12, "R3 first request width", first_w, 12);
        chk(lock_flag == 1'b0, "R4 lock lost on wide request", lock_flag, 0);
        chk(cur_high == 1'b1, "R5 current follows select when unlocked", cur_high, 1);
    endtask

    initial begin
        int p, req_seen;
        int rlist[7] = '{2, 3, 7, 100, 333, 0, 1};

        // R12 reset state
        wait_neg(2);
        chk({pump_up, pump_dn, cur_high, pump_off, drive_off, lock_flag,
             tp_a_en, tp_a_val, tp_b_en, tp_b_val} == 10'b0, "R12 reset outputs zero",
            {pump_up, pump_dn, cur_high, pump_off, drive_off, lock_flag,
             tp_a_en, tp_a_val, tp_b_en, tp_b_val}, 0);

        // matched loop: lock, no requests
        rst_n = 1'b1;
        req_seen = 0;
        for (int i = 0; i < 6 * 512; i++) begin
            @(negedge clk);
            if (pump_up || pump_dn) req_seen++;
        end
        chk(req_seen == 0, "R3 coincident strobes give no request", req_seen, 0);
        chk(lock_flag == 1'b1, "R4 locked after matched cycles", lock_flag, 1);
        chk(cur_high == 1'b0, "R5 current low while locked", cur_high, 0);

        // R8 test selects ignored when test mode off
        for (int s = 0; s < 4; s++) begin
            tsel = {s[1:0], 1'b1};
            wait_neg(3);
            chk(!tp_a_en && !tp_b_en, "R8 no override when test off", {tp_a_en, tp_b_en}, 0);
            chk(!pump_up && !pump_dn && lock_flag, "R8 loop unaffected by selects",
                {pump_up, pump_dn, lock_flag}, 1);
        end

        // R9 forced modes on a locked loop
        test_en = 1'b1; tsel = 3'b001;
        wait_neg(2);
        chk(pump_dn && !pump_up && !lock_flag, "R9 forced down, flag low",
            {pump_up, pump_dn, lock_flag}, 3'b010);
        tsel = 3'b011;
        wait_neg(2);
        chk(pump_up && !pump_dn && lock_flag, "R9 forced up, flag high",
            {pump_up, pump_dn, lock_flag}, 3'b101);
        // R6 pump kill wins over forcing
        pump_kill = 1'b1;
        wait_neg(2);
        chk(!pump_up && !pump_dn && pump_off, "R6 kill idles pump",
            {pump_up, pump_dn, pump_off}, 3'b001);
        tsel = 3'b001;
        wait_neg(2);
        chk(!pump_up && !pump_dn, "R6 kill idles forced down", {pump_up, pump_dn}, 0);
        pump_kill = 1'b0;
        // R7 drive disable
        drive_kill = 1'b1;
        wait_neg(2);
        chk(drive_off == 1'b1, "R7 drive off set", drive_off, 1);
        drive_kill = 1'b0;
        wait_neg(2);
        chk(drive_off == 1'b0, "R7 drive off cleared", drive_off, 0);

        // R2 / R11 reference period on test point B
        tsel = 3'b111;
        period_of(1'b1, p);
        period_of(1'b1, p);
        chk(p == 512, "R2 short reference period", p, 512);
        chk(tp_a_en && tp_b_en, "R11 both overrides enabled", {tp_a_en, tp_b_en}, 3);
        period_of(1'b0, p);
        chk(p == 512, "R11 feedback strobe on test point A", p, 512);
        tsel = 3'b110;
        period_of(1'b1, p);
        period_of(1'b1, p);
        chk(p == 1024, "R2 long reference period", p, 1024);

        // R1 ratio sweep under two strobe patterns
        tsel = 3'b111;
        for (int d = 1; d <= 3; d += 2) begin
            rf_div = d;
            foreach (rlist[k]) begin
                if (d == 1 && rlist[k] < 2) continue;
                ratio = 15'(rlist[k]);
                period_of(1'b0, p);
                period_of(1'b0, p);
                period_of(1'b0, p);
                chk(p == ((rlist[k] < 2) ? 1 : rlist[k]) * d, "R1 feedback period", p,
                    ((rlist[k] < 2) ? 1 : rlist[k]) * d);
            end
        end

        // R10 half-rate square wave
        rf_div = 1; ratio = 15'd50; tsel = 3'b101;
        period_of(1'b0, p);
        period_of(1'b0, p);
        chk(p == 100, "R10 half-rate period", p, 100);
        chk(tp_a_en && !tp_b_en, "R10 only test point A enabled", {tp_a_en, tp_b_en}, 2);

        // R3 / R4 / R5 offset ratios
        try_offset(500, 1'b0);
        try_offset(524, 1'b1);

        finish_run();
    end
endmodule